// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers 32 interrupt inputs into a single request line for a processor. Every input passes through a two-flop synchroniser and then a per-source trigger cell. Software picks edge or level triggering and the active polarity for each source independently. Any trigger event latches a pending bit for that source.

Pending bits are combined with a per-source enable mask to form a masked status word. A registered request output is raised whenever that word is non-zero.

Software reaches the block through a plain 32-bit register port with a strobe, a write flag and a byte address. A pending bit is acknowledged by writing one to its position in the clear register. A level source that is acknowledged while its input is still active stays pending, so no acknowledge can hide a live request. An edge event stays latched until it is acknowledged, however briefly the input pulsed.

Top module: `intc_top`

## Requirements
- R1: After reset, the enable, trigger-mode and trigger-polarity registers read 0, no bit is pending, and `irq_o` is 0.
- R2: The register map is as follows. Offset 0x00 is raw pending (read-only). Offset 0x04 is enable. Offset 0x08 is clear (write-only, always reads 0). Offset 0x0C is trigger mode. Offset 0x10 is trigger polarity. Offset 0x14 is masked status (read-only). Enable, mode and polarity read back the last value written.
- R3: Masked status equals raw pending AND enable. `irq_o` is 1 exactly when masked status was non-zero on the previous clock edge.
- R4: Writing the clear register clears pending bit n only where data bit n is 1. Bits written 0 keep their pending state.
- R5: A source with mode bit 0 and polarity bit 0 (level, active-high) becomes pending while its input is 1. Its pending bit stays latched until it is cleared.
- R6: A source with mode bit 0 and polarity bit 1 (level, active-low) becomes pending while its input is 0.
- R7: A source with mode bit 1 and polarity bit 0 becomes pending on a rising input edge. It stays pending after the input returns low. Holding the input high produces only one event.
- R8: A source with mode bit 1 and polarity bit 1 becomes pending on a falling input edge only. A rising edge does not set it.
- R9: If a clear and a trigger hit the same source in one cycle, the trigger wins. A level source cleared while its input is still active therefore remains pending.
- R10: An input change driven before clock edge k sets the pending bit at edge k+2, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt source inputs |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the access |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
A corrupted pending bit shows in the raw pending word on the next read. It reaches `irq_o` one edge later when the source is enabled. Errors in the trigger decoding appear three edges after an input change: as a missing pending bit, a spurious one, or a bit that clears when it should hold. A broken enable or mask path shows as a status word that disagrees with raw pending AND enable, or as an `irq_o` that disagrees with that status one cycle later.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc_trig.sv
module intc_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic edge_mode_i,
  input  logic low_act_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, hit;

  always_comb begin
    if (edge_mode_i) hit = low_act_i ? (prev_q & ~in_i) : (in_i & ~prev_q);
    else             hit = in_i ^ low_act_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= in_i;
      // set has priority over clear
      pend_q <= hit | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  logic [NUM_SRC-1:0] en_q, mode_q, pol_q;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFF_ENABLE) en_q   <= wdata_i;
      if (addr_i == OFF_MODE)   mode_q <= wdata_i;
      if (addr_i == OFF_POL)    pol_q  <= wdata_i;
    end
  end

  assign clr_o = (wr && addr_i == OFF_CLEAR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFF_RAW:    rdata_o = raw_i;
        OFF_ENABLE: rdata_o = en_q;
        OFF_MODE:   rdata_o = mode_q;
        OFF_POL:    rdata_o = pol_q;
        OFF_STATUS: rdata_o = status_i;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_sync, pend, status, en_q, mode_q, pol_q, clr_vec;
  logic irq_q;

  intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    intc_trig u_trig (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_i       (src_sync[i]),
      .edge_mode_i(mode_q[i]),
      .low_act_i  (pol_q[i]),
      .clr_i      (clr_vec[i]),
      .pend_o     (pend[i])
    );
  end

  assign status = pend & en_q;

  intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .raw_i   (pend),
    .status_i(status),
    .en_o    (en_q),
    .mode_o  (mode_q),
    .pol_o   (pol_q),
    .clr_o   (clr_vec),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |status;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] sync_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] mode_i,
  input logic [NUM_SRC-1:0] pol_i,
  input logic [NUM_SRC-1:0] clr_i
);
  AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(pend_i & en_i)))); // R3

  AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_STATUS) |-> ((rdata_o & ~en_i) == '0)); // R3

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_CLEAR) |-> (rdata_o == '0)); // R2

  AST_LEVEL_REPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(~mode_i & (sync_i ^ pol_i)) & ~pend_i) == '0)); // R9

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_i & ~clr_i) & ~pend_i) == '0)); // R7
endmodule

bind intc_top intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .sync_i (src_sync),
  .pend_i (pend),
  .en_i   (en_q),
  .mode_i (mode_q),
  .pol_i  (pol_q),
  .clr_i  (clr_vec)
);

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] A_RAW = 8'h00, A_EN = 8'h04, A_CLR = 8'h08,
                         A_MODE = 8'h0C, A_POL = 8'h10, A_STAT = 8'h14;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_RAW, v);  chk("R1 raw", v, 0);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_POL, v);  chk("R1 polarity", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_EN, 32'h1234_5678);   rd(A_EN, v);   chk("R2 enable rw", v, 32'h1234_5678);
    wr(A_MODE, 32'hCAFE_0000); rd(A_MODE, v); chk("R2 mode rw", v, 32'hCAFE_0000);
    wr(A_POL, 32'h0000_BEEF);  rd(A_POL, v);  chk("R2 pol rw", v, 32'h0000_BEEF);
    rd(A_CLR, v); chk("R2 clear reads 0", v, 0);
    wr(A_EN, 0); wr(A_MODE, 0); wr(A_POL, 0);
    wr(A_CLR, 32'hFFFF_FFFF);
    wait_cyc(2);
    rd(A_RAW, v); chk("R2 raw after restore", v, 0);
  endtask

  task automatic t_level_hi();
    logic [31:0] v;
    @(negedge clk); src[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(A_RAW, v); chk("R10 not yet pending", v, 0);
    @(posedge clk);
    rd(A_RAW, v); chk("R10 pending at third edge", v, 32'h200);
    chk("R5 level high pending", v, 32'h200);
    rd(A_STAT, v); chk("R3 status masked off", v, 0);
    chk("R3 irq low when disabled", {31'd0, irq}, 0);
    wr(A_EN, 32'h200);
    wait_cyc(2);
    rd(A_STAT, v); chk("R3 status enabled", v, 32'h200);
    chk("R3 irq high", {31'd0, irq}, 1);
    wr(A_EN, 0);
    wait_cyc(2);
    chk("R3 irq drops when disabled", {31'd0, irq}, 0);
    rd(A_RAW, v); chk("R3 raw kept when disabled", v, 32'h200);
  endtask

  task automatic t_repend();
    logic [31:0] v;
    wr(A_CLR, 32'h200);
    rd(A_RAW, v); chk("R9 level re-pends", v, 32'h200);
    @(negedge clk); src[9] = 1'b0;
    wait_cyc(4);
    rd(A_RAW, v); chk("R5 level latched after input low", v, 32'h200);
    wr(A_CLR, 32'h200);
    rd(A_RAW, v); chk("R9 clears once inactive", v, 0);
  endtask

  task automatic t_clear_mask();
    logic [31:0] v;
    @(negedge clk); src[9] = 1'b1;
    wait_cyc(4);
    @(negedge clk); src[9] = 1'b0;
    wait_cyc(4);
    wr(A_CLR, 0);
    rd(A_RAW, v); chk("R4 zero write no effect", v, 32'h200);
    wr(A_CLR, ~32'h200);
    rd(A_RAW, v); chk("R4 other bits no effect", v, 32'h200);
    wr(A_CLR, 32'h200);
    rd(A_RAW, v); chk("R4 one clears", v, 0);
  endtask

  task automatic t_level_lo();
    logic [31:0] v;
    wr(A_POL, 32'h80);
    wait_cyc(3);
    rd(A_RAW, v); chk("R6 active-low pending", v, 32'h80);
    @(negedge clk); src[7] = 1'b1;
    wait_cyc(4);
    wr(A_CLR, 32'h80);
    wait_cyc(3);
    rd(A_RAW, v); chk("R6 high input idle", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(A_MODE, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    wait_cyc(5);
    rd(A_RAW, v); chk("R7 pulse latched", v, 32'h8);
    wr(A_CLR, 32'h8);
    wait_cyc(4);
    rd(A_RAW, v); chk("R7 no event while idle", v, 0);
    @(negedge clk); src[3] = 1'b1;
    wait_cyc(5);
    wr(A_CLR, 32'h8);
    wait_cyc(4);
    rd(A_RAW, v); chk("R7 held high gives one event", v, 0);
    @(negedge clk); src[3] = 1'b0;
    wait_cyc(4);
    rd(A_RAW, v); chk("R7 falling ignored", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(A_MODE, 32'h28);
    wr(A_POL, 32'hA0);
    @(negedge clk); src[5] = 1'b1;
    wait_cyc(5);
    rd(A_RAW, v); chk("R8 rise ignored", v, 0);
    @(negedge clk); src[5] = 1'b0;
    wait_cyc(5);
    rd(A_RAW, v); chk("R8 fall latched", v, 32'h20);
    chk("R3 irq low, none enabled", {31'd0, irq}, 0);
    wr(A_EN, 32'h20);
    wait_cyc(2);
    chk("R3 irq high after enable", {31'd0, irq}, 1);
    wr(A_CLR, 32'h20);
    wait_cyc(2);
    rd(A_STAT, v); chk("R8 cleared", v, 0);
    chk("R3 irq low after clear", {31'd0, irq}, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_regs();
    t_level_hi();
    t_repend();
    t_clear_mask();
    t_level_lo();
    t_rise();
    t_fall();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule